// File: doc/BRIEF.md
# Input Event Edge Timestamper

This block watches an asynchronous timing input, either a once-per-second alignment pulse or a reference clock whose edges are of interest. When a qualifying transition arrives it records the current value of the local time counter. Software chooses the transitions that qualify: rising only, falling only, or both. The time counter is outside the block and arrives as a seconds word and a nanoseconds word, using the same format as the steerable clock. Each stamp resolves to one nanosecond.

The input passes through a two-flop synchronizer before edge detection. A captured stamp is the time that is present in the cycle in which the synchronized edge is detected, minus a configurable latency compensation in nanoseconds. The subtraction borrows from the seconds field when it has to. Each stamp and a flag giving the direction of its edge go into a small first-in first-out queue. Software sees the head entry, the fill level and a sticky overflow flag, and removes an entry with a one-cycle pop strobe.

When the timestamper is disabled it records nothing. The queue can be emptied with a flush strobe. When the queue is full, new events are dropped and the overflow flag is set.

Top module: `ets_event_stamper`

## Requirements
- R1: After a synchronous reset, rd_valid is 0, rd_level is 0 and ovf_flag is 0.
- R2: cfg_edge_sel selects the qualifying transitions: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none. A transition that does not qualify leaves rd_level unchanged.
- R3: rd_rising is 1 for an entry made by a low-to-high transition and 0 for an entry made by a high-to-low transition.
- R4: Two synchronizer flops and one edge register sit in front of the capture. The stamp uses the time presented during the third clock cycle after evt_in changes, and the entry is visible on the outputs after the third rising clock edge.
- R5: The stamp is the captured time minus cfg_lat_ns. When the captured nanoseconds value is below cfg_lat_ns, the seconds field is decremented and the nanoseconds field becomes ns + 1,000,000,000 - cfg_lat_ns. The stamp's nanoseconds field is always below 1,000,000,000.
- R6: Entries are read out in arrival order. The queue holds up to 8 entries, and rd_level gives the number of stored entries.
- R7: A qualifying event that arrives while the queue is full is dropped and sets ovf_flag. ovf_flag stays set until a ctl_ovf_clr pulse clears it. A set that coincides with a clear wins.
- R8: While cfg_enable is 0, no event is stored.
- R9: A ctl_flush pulse empties the queue one cycle later and does not change ovf_flag.
- R10: rd_pop removes the head entry. A pop while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous timing input |
| tod_sec | input | 48 | Time counter, seconds |
| tod_ns | input | 30 | Time counter, nanoseconds |
| cfg_enable | input | 1 | Capture enable |
| cfg_edge_sel | input | 2 | Selects the qualifying transitions |
| cfg_lat_ns | input | LAT_W (16) | Latency compensation in ns |
| ctl_flush | input | 1 | Empties the queue |
| ctl_ovf_clr | input | 1 | Clears the overflow flag |
| rd_pop | input | 1 | Removes the head entry |
| rd_valid | output | 1 | The queue is not empty |
| rd_sec | output | 48 | Head entry, seconds |
| rd_ns | output | 30 | Head entry, nanoseconds |
| rd_rising | output | 1 | Head entry, edge direction |
| rd_level | output | $clog2(DEPTH+1) (4) | Number of stored entries |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
An input change driven on a falling clock edge becomes a stored entry at the third rising edge that follows. The bench therefore waits three falling edges before it compares the head entry and rd_level. In one test a different time value is presented on each of those cycles, to show which cycle's time is captured. Strobes such as pop, flush and overflow clear act at the next rising edge, so their effect is sampled one falling edge after they are raised. A scoreboard queue holds the expected stamps, computed from the requirement formula, and the queue is compared entry by entry as the block is drained.

// File: rtl/ets_pkg.sv
package ets_pkg;
    parameter int SEC_W = 48;
    parameter int NS_W  = 30;
    localparam logic [NS_W:0] NS_PER_SEC = (NS_W+1)'(1000000000);

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic             rising;
    } stamp_t;

    // Subtract a latency in ns from a time value, borrowing a second if needed.
    function automatic stamp_t comp_latency(input logic [SEC_W-1:0] sec,
                                            input logic [NS_W-1:0] ns,
                                            input logic [NS_W-1:0] lat,
                                            input logic rising);
        stamp_t r;
        logic [NS_W:0] wide;
        r.rising = rising;
        if (ns >= lat) begin
            r.sec = sec;
            r.ns  = ns - lat;
        end else begin
            r.sec = sec - 1'b1;
            wide  = {1'b0, ns} + NS_PER_SEC - {1'b0, lat};
            r.ns  = wide[NS_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/ets_sync_edge.sv
module ets_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // R2: a detected transition has one direction only
    p_one_dir_r2: assert property (@(posedge clk) disable iff (rst) $onehot0({rise, fall}));
    // R4: a rise appears two cycles after the input was sampled high
    p_rise_delay_r4: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(meta_q));
endmodule

// File: rtl/ets_stamp_fifo.sv
module ets_stamp_fifo
    import ets_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  stamp_t        push_data,
    input  logic          pop,
    input  logic          flush,
    input  logic          ovf_clr,
    output stamp_t        head,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          ovf
);
    stamp_t        mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst)                   ovf <= 1'b0;
        else if (push && full)     ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end

    assign head = mem[rd_ptr];

    // R6: the level never passes the depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
    // R7: an event into a full queue raises the flag
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> ovf);
    // R7: flag is sticky without a clear
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
    // R9: flush empties the queue
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst) flush |=> empty);
    // R10: pop on an empty queue leaves it empty
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);
endmodule

// File: rtl/ets_event_stamper.sv
module ets_event_stamper
    import ets_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LAT_W = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_in,
    input  logic [SEC_W-1:0] tod_sec,
    input  logic [NS_W-1:0]  tod_ns,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_edge_sel,
    input  logic [LAT_W-1:0] cfg_lat_ns,
    input  logic             ctl_flush,
    input  logic             ctl_ovf_clr,
    input  logic             rd_pop,
    output logic             rd_valid,
    output logic [SEC_W-1:0] rd_sec,
    output logic [NS_W-1:0]  rd_ns,
    output logic             rd_rising,
    output logic [CW-1:0]    rd_level,
    output logic             ovf_flag
);
    logic      rise, fall, qualify, fifo_empty;
    edge_sel_e sel;
    stamp_t    new_stamp, head;

    ets_sync_edge u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (evt_in),
        .rise     (rise),
        .fall     (fall)
    );

    assign sel = edge_sel_e'(cfg_edge_sel);

    always_comb begin
        unique case (sel)
            EDGE_RISE: qualify = rise;
            EDGE_FALL: qualify = fall;
            EDGE_BOTH: qualify = rise | fall;
            default:   qualify = 1'b0;
        endcase
        qualify = qualify & cfg_enable;
    end

    assign new_stamp = comp_latency(tod_sec, tod_ns, NS_W'(cfg_lat_ns), rise);

    ets_stamp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (qualify),
        .push_data (new_stamp),
        .pop       (rd_pop),
        .flush     (ctl_flush),
        .ovf_clr   (ctl_ovf_clr),
        .head      (head),
        .empty     (fifo_empty),
        .count     (rd_level),
        .ovf       (ovf_flag)
    );

    assign rd_valid  = ~fifo_empty;
    assign rd_sec    = head.sec;
    assign rd_ns     = head.ns;
    assign rd_rising = head.rising;

    // R8: disabled block stores nothing
    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> rd_level <= $past(rd_level));
    // R5: stored nanoseconds stay in range
    p_ns_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ({1'b0, rd_ns} < NS_PER_SEC));
endmodule

// File: tb/ets_event_stamper_test.sv
module ets_event_stamper_test;
    import ets_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             evt_in = 1'b0;
    logic [SEC_W-1:0] tod_sec = '0;
    logic [NS_W-1:0]  tod_ns = '0;
    logic             cfg_enable = 1'b0;
    logic [1:0]       cfg_edge_sel = 2'b00;
    logic [15:0]      cfg_lat_ns = 16'd20;
    logic             ctl_flush = 1'b0, ctl_ovf_clr = 1'b0, rd_pop = 1'b0;
    logic             rd_valid, rd_rising, ovf_flag;
    logic [SEC_W-1:0] rd_sec;
    logic [NS_W-1:0]  rd_ns;
    logic [3:0]       rd_level;

    int tests = 0, fails = 0;
    stamp_t sb[$];

    ets_event_stamper uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic stamp_t expect_of(input logic [SEC_W-1:0] s, input logic [NS_W-1:0] n,
                                         input logic r);
        stamp_t e;
        longint t = longint'(s) * 1000000000 + longint'(n) - longint'(cfg_lat_ns);
        e.sec = SEC_W'(t / 1000000000);
        e.ns  = NS_W'(t % 1000000000);
        e.rising = r;
        return e;
    endfunction

    // Driver: change the input, hold time, push the expected stamp if it qualifies.
    task automatic drive_edge(input logic lvl, input logic [SEC_W-1:0] s, input logic [NS_W-1:0] n,
                              input logic captured);
        @(negedge clk);
        evt_in = lvl; tod_sec = s; tod_ns = n;
        if (captured && sb.size() < 8) sb.push_back(expect_of(s, n, lvl));
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Monitor: pop and compare every expected entry.
    task automatic drain(input string req);
        while (sb.size() > 0) begin
            stamp_t e = sb.pop_front();
            chk({req, " valid"}, rd_valid, 1);
            chk({req, " sec"}, rd_sec, e.sec);
            chk({req, " ns"}, rd_ns, e.ns);
            chk({req, " dir R3"}, rd_rising, e.rising);
            pulse(rd_pop);
        end
        chk({req, " empty R10"}, rd_valid, 0);
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid", rd_valid, 0);
        chk("R1 level", rd_level, 0);
        chk("R1 ovf", ovf_flag, 0);
        cfg_enable = 1'b1;

        // R2 rising only
        cfg_edge_sel = 2'b01;
        drive_edge(1'b1, 48'd10, 30'd500, 1'b1);
        chk("R2 rise level", rd_level, 1);
        drive_edge(1'b0, 48'd10, 30'd900, 1'b0);
        chk("R2 fall ignored", rd_level, 1);
        // R2 falling only
        cfg_edge_sel = 2'b10;
        drive_edge(1'b1, 48'd11, 30'd100, 1'b0);
        chk("R2 rise ignored", rd_level, 1);
        drive_edge(1'b0, 48'd11, 30'd300, 1'b1);
        // R2 both
        cfg_edge_sel = 2'b11;
        drive_edge(1'b1, 48'd12, 30'd40, 1'b1);
        drive_edge(1'b0, 48'd12, 30'd77, 1'b1);
        chk("R2 both level", rd_level, 4);
        // R2 none
        cfg_edge_sel = 2'b00;
        drive_edge(1'b1, 48'd13, 30'd1, 1'b0);
        drive_edge(1'b0, 48'd13, 30'd2, 1'b0);
        chk("R2 none level", rd_level, 4);
        drain("R6 order");

        // R4 capture cycle: a different time each cycle
        cfg_edge_sel = 2'b11;
        @(negedge clk); evt_in = 1'b1; tod_sec = 48'd20; tod_ns = 30'd1000;
        @(negedge clk); tod_ns = 30'd2000;
        chk("R4 not yet", rd_level, 0);
        @(negedge clk); tod_ns = 30'd3000;
        chk("R4 not yet 2", rd_level, 0);
        sb.push_back(expect_of(48'd20, 30'd3000, 1'b1));
        @(negedge clk); tod_ns = 30'd4000;
        chk("R4 level", rd_level, 1);
        drain("R4");

        // R5 borrow across a second
        drive_edge(1'b0, 48'd30, 30'd5, 1'b1);
        chk("R5 borrow ns", rd_ns, 999999985);
        chk("R5 borrow sec", rd_sec, 29);
        drain("R5");

        // R6/R7 fill and overflow, rising only
        cfg_edge_sel = 2'b01;
        for (int i = 0; i < 9; i++) begin
            drive_edge(1'b1, 48'd40 + 48'(i), 30'd100 + 30'(i), 1'b1);
            drive_edge(1'b0, 48'd40, 30'd0, 1'b0);
        end
        chk("R6 full level", rd_level, 8);
        chk("R7 ovf set", ovf_flag, 1);
        drain("R7 kept entries");
        chk("R7 ovf sticky", ovf_flag, 1);
        pulse(ctl_ovf_clr);
        chk("R7 ovf cleared", ovf_flag, 0);

        // R8 disabled
        cfg_enable = 1'b0; cfg_edge_sel = 2'b11;
        drive_edge(1'b1, 48'd50, 30'd9, 1'b0);
        drive_edge(1'b0, 48'd50, 30'd9, 1'b0);
        chk("R8 disabled level", rd_level, 0);
        cfg_enable = 1'b1;

        // R9 flush
        drive_edge(1'b1, 48'd60, 30'd60, 1'b1);
        drive_edge(1'b0, 48'd60, 30'd61, 1'b1);
        chk("R9 before flush", rd_level, 2);
        pulse(ctl_flush);
        sb.delete();
        chk("R9 flushed level", rd_level, 0);
        chk("R9 flushed valid", rd_valid, 0);

        // R10 pop on empty ignored
        pulse(rd_pop);
        chk("R10 pop empty level", rd_level, 0);
        drive_edge(1'b1, 48'd70, 30'd700, 1'b1);
        chk("R10 after level", rd_level, 1);
        drain("R10");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule